// File: doc/BRIEF.md
# Cache Miss Type Classifier

This block labels every cache line fill as a capacity miss or a conflict miss. It keeps a history of recently filled line tags, in the order they arrived. The history has one entry for each line of the cache it watches. A tag that comes back while it is still in the history was pushed out of the cache early, before the cache had been refilled once, so the block reports a conflict miss. A tag that is absent means at least a cache's worth of other lines has arrived since it was last present, so the block reports a capacity miss.

The cache controller raises a strobe with the line tag on each fill. One cycle later the block presents a two-bit result with its own valid flag. The stored tags are compared against the incoming tag all at once, one comparator per slot, so the block takes a new tag on every cycle. A statistics-disable input turns classification off without touching the history. A sticky error flag reports any loss of agreement between the stored tags and the slot bookkeeping. An occupancy output shows how full the history is.

Top module: `miss_classifier`

## Requirements
- R1: After synchronous reset, res_valid is 0, err_flag is 0 and occupancy is 0.
- R2: A strobe on fill_valid in one cycle gives res_valid high on the next cycle. With no strobe, res_valid is low on the next cycle.
- R3: A tag that is not in the history gives res_kind 2'b01 (capacity). The tag is then appended as the newest entry.
- R4: A tag that is already in the history gives res_kind 2'b10 (conflict). The history is left unchanged: the entry is not moved to the newest position and the occupancy stays the same.
- R5: When the history is full and a capacity miss arrives, the oldest entry is removed and the new tag takes its place. A later strobe with the removed tag reports capacity, while the remaining entries still report conflict.
- R6: Back-to-back strobes carrying the same new tag report capacity on the first and conflict on the second.
- R7: While stats_off is high, a strobe gives res_kind 2'b00 (nonspecific) and leaves the history and the occupancy unchanged.
- R8: occupancy counts the stored tags and stops at DEPTH.
- R9: err_flag stays 0 for any legal input sequence. Once set, it stays set until reset.
- R10: Slots that have never been filled never match. A first strobe with tag 0 after reset reports capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_valid | input | 1 | One line fill is presented this cycle |
| fill_tag | input | TAG_W | Tag of the filled line |
| stats_off | input | 1 | Disables classification; results become nonspecific |
| res_valid | output | 1 | Result valid, one cycle after fill_valid |
| res_kind | output | 2 | 00 nonspecific, 01 capacity, 10 conflict |
| err_flag | output | 1 | Sticky error: history bookkeeping disagreement |
| occupancy | output | $clog2(DEPTH+1) | Number of tags held, saturating at DEPTH |

## Verification
The hardest case to reach is a full history in which a tag has just been hit and the next capacity miss must still evict that same tag, because it is the oldest. An order-sensitive model would move it to the newest position instead. The bench fills the history exactly, hits the oldest tag, pushes one new tag, and then probes both the evicted tag and its former neighbour. A long pseudo-random sweep follows, drawing from a tag range twice the depth so that hits, evictions, gaps and disabled strobes mix freely. Each result is compared against an ordered-queue reference kept in the bench.

// File: rtl/miss_cls_pkg.sv
package miss_cls_pkg;

    typedef enum logic [1:0] {
        KIND_NONSPEC  = 2'b00,
        KIND_CAPACITY = 2'b01,
        KIND_CONFLICT = 2'b10
    } miss_kind_e;

    typedef struct packed {
        logic       vld;
        miss_kind_e kind;
    } result_s;

    function automatic miss_kind_e pick_kind(input logic off, input logic hit);
        if (off)
            return KIND_NONSPEC;
        else if (hit)
            return KIND_CONFLICT;
        else
            return KIND_CAPACITY;
    endfunction

endpackage

// File: rtl/tag_probe.sv
module tag_probe #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [DEPTH-1:0][TAG_W-1:0]   slot_tags,
    input  logic [DEPTH-1:0]              slot_vld,
    input  logic [TAG_W-1:0]              probe_tag,
    output logic                          hit,
    output logic                          dup
);
    logic [DEPTH-1:0] match_vec;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign match_vec[i] = slot_vld[i] && (slot_tags[i] == probe_tag);
    end

    assign hit = |match_vec;
    assign dup = ($countones(match_vec) > 1);

    // R9
    unique_match_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match_vec));

endmodule

// File: rtl/tag_history.sv
module tag_history #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          push,
    input  logic [TAG_W-1:0]              push_tag,
    output logic [DEPTH-1:0][TAG_W-1:0]   slot_tags,
    output logic [DEPTH-1:0]              slot_vld,
    output logic [CNT_W-1:0]              count,
    output logic                          slot_err
);
    logic [PTR_W-1:0] wr_ptr;
    logic             full;

    assign full = (count == CNT_W'(DEPTH));

    // Full: the write slot is the oldest and must be occupied.
    // Not full: the write slot must still be free.
    assign slot_err = push && (full ? !slot_vld[wr_ptr] : slot_vld[wr_ptr]);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_vld[i]  <= 1'b0;
                slot_tags[i] <= '0;
            end else if (push && wr_ptr == PTR_W'(i)) begin
                slot_vld[i]  <= 1'b1;
                slot_tags[i] <= push_tag;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            count  <= '0;
        end else if (push) begin
            wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (!full)
                count <= count + 1'b1;
        end
    end

    // R8
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R5
    full_push_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (push && full) |=> (count == CNT_W'(DEPTH)));

endmodule

// File: rtl/miss_classifier.sv
module miss_classifier
    import miss_cls_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TAG_W = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_valid,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic              stats_off,
    output logic              res_valid,
    output logic [1:0]        res_kind,
    output logic              err_flag,
    output logic [CNT_W-1:0]  occupancy
);
    logic [DEPTH-1:0][TAG_W-1:0] slot_tags;
    logic [DEPTH-1:0]            slot_vld;
    logic                        hit, dup, slot_err, push, classify;
    result_s                     res_q;

    assign classify = fill_valid && !stats_off;
    assign push     = classify && !hit;

    tag_probe #(.DEPTH(DEPTH), .TAG_W(TAG_W)) i_probe (
        .clk(clk), .rst(rst),
        .slot_tags(slot_tags), .slot_vld(slot_vld),
        .probe_tag(fill_tag), .hit(hit), .dup(dup)
    );

    tag_history #(.DEPTH(DEPTH), .TAG_W(TAG_W)) i_hist (
        .clk(clk), .rst(rst),
        .push(push), .push_tag(fill_tag),
        .slot_tags(slot_tags), .slot_vld(slot_vld),
        .count(occupancy), .slot_err(slot_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q    <= '{vld: 1'b0, kind: KIND_NONSPEC};
            err_flag <= 1'b0;
        end else begin
            res_q.vld  <= fill_valid;
            res_q.kind <= pick_kind(stats_off, hit);
            if (classify && (dup || slot_err))
                err_flag <= 1'b1;
        end
    end

    assign res_valid = res_q.vld;
    assign res_kind  = res_q.kind;

    // R2
    result_follows_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        fill_valid |=> res_valid);

    // R2
    no_spurious_result_chk: assert property (@(posedge clk) disable iff (rst)
        !fill_valid |=> !res_valid);

    // R7
    disabled_nonspec_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && stats_off) |=> (res_kind == KIND_NONSPEC && $stable(occupancy)));

    // R4
    conflict_keeps_history_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_kind == KIND_CONFLICT) |-> $stable(occupancy));

    // R3
    capacity_grows_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_kind == KIND_CAPACITY) |->
            (occupancy == (($past(occupancy) == CNT_W'(DEPTH)) ? CNT_W'(DEPTH)
                                                               : $past(occupancy) + 1'b1)));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);

endmodule

// File: tb/test_miss_classifier.sv
`timescale 1ns/1ps
module test_miss_classifier;
    import miss_cls_pkg::*;

    localparam int DEPTH = 8;
    localparam int TAG_W = 8;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             fill_valid = 1'b0;
    logic [TAG_W-1:0] fill_tag = '0;
    logic             stats_off = 1'b0;
    logic             res_valid;
    logic [1:0]       res_kind;
    logic             err_flag;
    logic [CNT_W-1:0] occupancy;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    int model[$];

    always #4 clk = ~clk;

    miss_classifier #(.DEPTH(DEPTH), .TAG_W(TAG_W)) i_miss_classifier (
        .clk(clk), .rst(rst),
        .fill_valid(fill_valid), .fill_tag(fill_tag), .stats_off(stats_off),
        .res_valid(res_valid), .res_kind(res_kind),
        .err_flag(err_flag), .occupancy(occupancy)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic off,
                        input logic [TAG_W-1:0] t, input string rq);
        int idx;
        miss_kind_e exp;
        fill_valid = v;
        stats_off  = off;
        fill_tag   = t;
        exp = KIND_NONSPEC;
        if (v && !off) begin
            idx = -1;
            foreach (model[i]) if (model[i] == int'(t)) idx = i;
            if (idx >= 0) exp = KIND_CONFLICT;
            else begin
                exp = KIND_CAPACITY;
                if (model.size() == DEPTH) void'(model.pop_front());
                model.push_back(int'(t));
            end
        end
        @(negedge clk);
        fill_valid = 1'b0;
        stats_off  = 1'b0;
        chk(res_valid == v, rq, "res_valid", int'(res_valid), int'(v));
        if (v) chk(res_kind == exp, rq, "res_kind", int'(res_kind), int'(exp));
        chk(occupancy == CNT_W'(model.size()), "R8", "occupancy",
            int'(occupancy), model.size());
        chk(err_flag == 1'b0, "R9", "err_flag", int'(err_flag), 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(res_valid == 1'b0, "R1", "res_valid", int'(res_valid), 0);
        chk(err_flag == 1'b0, "R1", "err_flag", int'(err_flag), 0);
        chk(occupancy == '0, "R1", "occupancy", int'(occupancy), 0);

        // R10: empty slots hold zero tags but must not match
        step(1, 0, 8'h00, "R10");
        // R2: idle cycle gives no result
        step(0, 0, 8'h00, "R2");
        // R3: fill to capacity
        for (int k = 1; k < DEPTH; k++) step(1, 0, TAG_W'(k), "R3");
        // R4: hit the oldest; it must not move
        step(1, 0, 8'h00, "R4");
        // R5: new tag evicts tag 0 despite the hit
        step(1, 0, 8'h64, "R5");
        step(1, 0, 8'h00, "R5");   // capacity again, evicts 1
        step(1, 0, 8'h02, "R5");   // still present: conflict
        step(1, 0, 8'h01, "R5");   // evicted: capacity
        // R6: same new tag back to back
        step(1, 0, 8'hC8, "R6");
        step(1, 0, 8'hC8, "R6");
        // R7: disabled strobes leave history alone
        step(1, 1, 8'hC9, "R7");
        step(1, 1, 8'hC8, "R7");
        step(1, 0, 8'hC9, "R7");
        step(1, 0, 8'hC8, "R7");

        // sweep
        lfsr = 8'h5A;
        for (int n = 0; n < 600; n++) begin
            logic v, off;
            string rq;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            v   = (lfsr[6:5] != 2'b00);
            off = (lfsr[7:5] == 3'b111);
            rq  = off ? "R7" : "R3";
            foreach (model[i]) if (model[i] == int'(lfsr[3:0])) rq = off ? "R7" : "R4";
            step(v, off, TAG_W'(lfsr[3:0]), rq);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule